// File: doc/BRIEF.md
# Partitioned Subword Integer ALU Lane

This block is one 64-bit lane of a vector integer ALU. In a single cycle it runs one operation on the whole word, on two 32-bit halves, on four 16-bit quarters or on eight bytes. A width select chooses the split, and no carry, borrow or shifted bit ever crosses from one element into the next. The same adder, multiplier and shifters serve every split. Each element is handled as a separate narrow integer.

Operands come in three forms. In vector-vector form, element i of one word combines with element i of the other. In vector-scalar form, the vector element combines with a scalar. In scalar-vector form the scalar is the left operand, so subtraction and shifts take the scalar as the value and the vector element as the second operand. In both scalar forms the scalar is taken from the low bits of a scalar input and copied into every element.

Signed and unsigned modes are available, and saturation can replace wraparound. A per-element mask and a vector-length count decide which elements the register file may write. The result and the per-element write enables come out one cycle after the inputs are accepted.

Top module: `simd_subword_lane`

## Requirements
- R1: `ewSel` picks the element width: 0 gives eight 8-bit elements, 1 gives four 16-bit elements, 2 gives two 32-bit elements and 3 gives one 64-bit element. Element i occupies result bits [i*W +: W], and its arithmetic never affects any other element.
- R2: `form` picks the operand form. 0 gives vecA op vecB. 1 gives vecA op S. 2 gives S op vecA. S is `scalarIn[W-1:0]`, copied into every element. The value 3 behaves like 0.
- R3: `opcode` 0 adds, 1 subtracts (left minus right), 2 multiplies and keeps the low W bits, 3 shifts left, and 4 shifts right. Codes 5 to 7 write no element.
- R4: With `isSigned`=1 the operands are two's complement and right shift is arithmetic. With `isSigned`=0 the operands are unsigned and right shift fills with zeros.
- R5: For add, subtract and multiply, `saturate`=1 clamps the exact result to the element's range. That range is [-2^(W-1), 2^(W-1)-1] when signed and [0, 2^W-1] when unsigned. `saturate`=0 keeps the result modulo 2^W. Shifts never saturate.
- R6: A shift moves the left operand by the right operand's element value modulo W. Bits shifted out are dropped.
- R7: With `maskEn`=1, element i is written only when `mask[i]` is 1. With `maskEn`=0 the mask has no effect.
- R8: Element i is written only when i < `vlen`. When `vlen` is 0, nothing is written.
- R9: `outValid` rises exactly one cycle after `inValid`, and `result` and `wrEn` belong to that cycle. `wrEn[i]` marks element i and is all zero whenever `outValid` is low. `result` holds its value while no input is valid.
- R10: After reset, `outValid`, `wrEn` and `result` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Operation present this cycle |
| opcode | input | 3 | Operation code (R3) |
| form | input | 2 | Operand form (R2) |
| ewSel | input | 2 | Element width select (R1) |
| isSigned | input | 1 | Signed mode |
| saturate | input | 1 | Saturate instead of wrap |
| maskEn | input | 1 | Apply the element mask |
| mask | input | 8 | One flag per element index |
| vlen | input | 4 | Number of active elements (0 to 8) |
| vecA | input | 64 | Vector operand A |
| vecB | input | 64 | Vector operand B |
| scalarIn | input | 64 | Scalar operand, low W bits used |
| outValid | output | 1 | Result valid |
| result | output | 64 | Packed element results |
| wrEn | output | 8 | Write enable per element index |

## Verification
The bench sweeps every width, operation, form, sign mode and saturation setting. Operand patterns sit at the edges of the signed and unsigned ranges, where a carry that leaked across a subword boundary would corrupt the element above it. A design that clamped against the wrong width or the wrong signedness would return a wrong saturated value. A design that ignored the operand swap in scalar-vector form would get subtraction and shift results backwards. A design with a logical right shift where an arithmetic one belongs would lose the sign fill. Shift amounts of W and above test the modulo rule. Sweeps of the mask and of the vector length catch write enables that ignore either control or light up indices past the element count.

// File: rtl/lane_pkg.sv
package lane_pkg;
  localparam logic [2:0] OP_ADD = 3'd0;
  localparam logic [2:0] OP_SUB = 3'd1;
  localparam logic [2:0] OP_MUL = 3'd2;
  localparam logic [2:0] OP_SHL = 3'd3;
  localparam logic [2:0] OP_SHR = 3'd4;

  localparam logic [1:0] FORM_VV = 2'd0;
  localparam logic [1:0] FORM_VS = 2'd1;
  localparam logic [1:0] FORM_SV = 2'd2;

  // Strobes sent from the control to the datapath
  typedef struct packed {
    logic selAdd;
    logic selSub;
    logic selMul;
    logic selShl;
    logic selShr;
    logic isSigned;
    logic saturate;
    logic useScalar;
    logic swapOrder;
    logic load;
  } lane_strobe_t;
endpackage

// File: rtl/lane_ctrl.sv
module lane_ctrl
  import lane_pkg::*;
#(
  parameter int SLOTS = 8,
  parameter int VL_W  = $clog2(SLOTS) + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [2:0]       opcode,
  input  logic [1:0]       form,
  input  logic [1:0]       ewSel,
  input  logic             isSigned,
  input  logic             saturate,
  input  logic             maskEn,
  input  logic [SLOTS-1:0] mask,
  input  logic [VL_W-1:0]  vlen,
  output lane_strobe_t     strobe,
  output logic             outValid,
  output logic [SLOTS-1:0] wrEn
);
  localparam int CW = VL_W + 1;

  logic             opKnown;
  logic [CW-1:0]    nElem;
  logic [SLOTS-1:0] enNext;

  always_comb begin
    strobe           = '0;
    strobe.selAdd    = (opcode == OP_ADD);
    strobe.selSub    = (opcode == OP_SUB);
    strobe.selMul    = (opcode == OP_MUL);
    strobe.selShl    = (opcode == OP_SHL);
    strobe.selShr    = (opcode == OP_SHR);
    strobe.isSigned  = isSigned;
    strobe.saturate  = saturate;
    strobe.useScalar = (form == FORM_VS) || (form == FORM_SV);
    strobe.swapOrder = (form == FORM_SV);
    strobe.load      = inValid;
    opKnown = strobe.selAdd | strobe.selSub | strobe.selMul | strobe.selShl | strobe.selShr;
  end

  always_comb begin
    nElem = CW'(SLOTS) >> ewSel;
    for (int i = 0; i < SLOTS; i++) begin
      enNext[i] = opKnown && (CW'(i) < nElem) && (CW'(i) < {1'b0, vlen})
                  && (!maskEn || mask[i]);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      wrEn     <= '0;
    end else begin
      outValid <= inValid;
      wrEn     <= inValid ? enNext : '0;
    end
  end
endmodule

// File: rtl/lane_datapath.sv
module lane_datapath
  import lane_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int MIN_W  = 8,
  parameter int NW     = $clog2(DATA_W / MIN_W) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  lane_strobe_t      strobe,
  input  logic [1:0]        ewSel,
  input  logic [DATA_W-1:0] vecA,
  input  logic [DATA_W-1:0] vecB,
  input  logic [DATA_W-1:0] scalarIn,
  output logic [DATA_W-1:0] result
);
  logic [DATA_W-1:0] widthRes [NW];
  logic [DATA_W-1:0] nextRes;

  for (genvar g = 0; g < NW; g++) begin : gWidth
    localparam int W  = MIN_W << g;
    localparam int N  = DATA_W / W;
    localparam int K  = 2 * W + 2;
    localparam int SH = $clog2(W);
    logic [DATA_W-1:0] packedRes;

    for (genvar e = 0; e < N; e++) begin : gElem
      logic [W-1:0] aV, bV, sV, x, y, arith, shl, shr, res;
      logic [K-1:0] xe, ye, wide;

      always_comb begin
        aV = vecA[e*W +: W];
        bV = vecB[e*W +: W];
        sV = scalarIn[W-1:0];
        x  = strobe.swapOrder ? sV : aV;
        y  = strobe.swapOrder ? aV : (strobe.useScalar ? sV : bV);
        xe = {{(K-W){strobe.isSigned & x[W-1]}}, x};
        ye = {{(K-W){strobe.isSigned & y[W-1]}}, y};

        wide = '0;
        if (strobe.selAdd) wide = xe + ye;
        if (strobe.selSub) wide = xe - ye;
        if (strobe.selMul) wide = xe * ye;

        arith = wide[W-1:0];
        if (strobe.saturate) begin
          if (strobe.isSigned) begin
            if ((|wide[K-1:W-1]) && !(&wide[K-1:W-1]))
              arith = wide[K-1] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
          end else begin
            if (wide[K-1])             arith = '0;
            else if (|wide[K-2:W])     arith = '1;
          end
        end

        shl = x << y[SH-1:0];
        if (strobe.isSigned) shr = $signed(x) >>> y[SH-1:0];
        else                 shr = x >> y[SH-1:0];

        res = '0;
        if (strobe.selAdd | strobe.selSub | strobe.selMul) res = arith;
        if (strobe.selShl) res = shl;
        if (strobe.selShr) res = shr;
      end

      assign packedRes[e*W +: W] = res;
    end

    assign widthRes[g] = packedRes;
  end

  assign nextRes = widthRes[ewSel];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            result <= '0;
    else if (strobe.load) result <= nextRes;
  end
endmodule

// File: rtl/simd_subword_lane.sv
module simd_subword_lane
  import lane_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int MIN_W  = 8
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  logic                                 inValid,
  input  logic [2:0]                           opcode,
  input  logic [1:0]                           form,
  input  logic [1:0]                           ewSel,
  input  logic                                 isSigned,
  input  logic                                 saturate,
  input  logic                                 maskEn,
  input  logic [DATA_W/MIN_W-1:0]              mask,
  input  logic [$clog2(DATA_W/MIN_W):0]        vlen,
  input  logic [DATA_W-1:0]                    vecA,
  input  logic [DATA_W-1:0]                    vecB,
  input  logic [DATA_W-1:0]                    scalarIn,
  output logic                                 outValid,
  output logic [DATA_W-1:0]                    result,
  output logic [DATA_W/MIN_W-1:0]              wrEn
);
  localparam int SLOTS = DATA_W / MIN_W;
  localparam int VL_W  = $clog2(SLOTS) + 1;

  lane_strobe_t strobe;

  lane_ctrl #(.SLOTS(SLOTS), .VL_W(VL_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opcode(opcode), .form(form),
    .ewSel(ewSel), .isSigned(isSigned), .saturate(saturate), .maskEn(maskEn),
    .mask(mask), .vlen(vlen), .strobe(strobe), .outValid(outValid), .wrEn(wrEn)
  );

  lane_datapath #(.DATA_W(DATA_W), .MIN_W(MIN_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .ewSel(ewSel), .vecA(vecA),
    .vecB(vecB), .scalarIn(scalarIn), .result(result)
  );
endmodule

// File: rtl/lane_checker.sv
module lane_checker #(
  parameter int DATA_W = 64,
  parameter int MIN_W  = 8
) (
  input logic                                 clk,
  input logic                                 rstN,
  input logic                                 inValid,
  input logic [2:0]                           opcode,
  input logic [1:0]                           ewSel,
  input logic                                 maskEn,
  input logic [DATA_W/MIN_W-1:0]              mask,
  input logic [$clog2(DATA_W/MIN_W):0]        vlen,
  input logic                                 outValid,
  input logic [DATA_W-1:0]                    result,
  input logic [DATA_W/MIN_W-1:0]              wrEn
);
  p_valid_latency_r9: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> (!outValid && wrEn == '0));
  p_hold_result_r9: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(result));
  p_zero_length_r8: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && vlen == '0) |=> wrEn == '0);
  p_mask_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && maskEn && mask == '0) |=> wrEn == '0);
  p_single_element_r1: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && ewSel == 2'd3) |=> $countones(wrEn) <= 1);
  p_bad_opcode_r3: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opcode > 3'd4) |=> wrEn == '0);
endmodule

bind simd_subword_lane lane_checker #(.DATA_W(DATA_W), .MIN_W(MIN_W)) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .opcode(opcode), .ewSel(ewSel),
  .maskEn(maskEn), .mask(mask), .vlen(vlen), .outValid(outValid),
  .result(result), .wrEn(wrEn)
);

// File: tb/tb_simd_subword_lane.sv
module tb_simd_subword_lane;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [2:0]  opcode = '0;
  logic [1:0]  form = '0;
  logic [1:0]  ewSel = '0;
  logic        isSigned = 1'b0;
  logic        saturate = 1'b0;
  logic        maskEn = 1'b0;
  logic [7:0]  mask = '0;
  logic [3:0]  vlen = 4'd8;
  logic [63:0] vecA = '0;
  logic [63:0] vecB = '0;
  logic [63:0] scalarIn = '0;
  logic        outValid;
  logic [63:0] result;
  logic [7:0]  wrEn;

  int  nTests = 0;
  int  nFails = 0;
  bit  done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  simd_subword_lane dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opcode(opcode), .form(form),
    .ewSel(ewSel), .isSigned(isSigned), .saturate(saturate), .maskEn(maskEn),
    .mask(mask), .vlen(vlen), .vecA(vecA), .vecB(vecB), .scalarIn(scalarIn),
    .outValid(outValid), .result(result), .wrEn(wrEn)
  );

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    nTests++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] rep(int w, logic [63:0] v);
    logic [63:0] r;
    for (int b = 0; b < 64; b++) r[b] = v[b % w];
    return r;
  endfunction

  function automatic logic [63:0] getElem(logic [63:0] v, int w, int i);
    logic [63:0] r = '0;
    for (int b = 0; b < w; b++) r[b] = v[i*w + b];
    return r;
  endfunction

  function automatic logic [63:0] modelElem(int w, logic [63:0] a, logic [63:0] b,
                                            int op, bit sg, bit sat);
    logic signed [129:0] full, sa, sb, r, lo, hi;
    int amt;
    full = 130'sd1 <<< w;
    sa = {66'd0, a};
    sb = {66'd0, b};
    if (sg && a[w-1]) sa = sa - full;
    if (sg && b[w-1]) sb = sb - full;
    amt = int'(b[5:0]) % w;
    r = '0;
    case (op)
      0: r = sa + sb;
      1: r = sa - sb;
      2: r = sa * sb;
      3: r = {66'd0, a} << amt;
      4: r = sg ? (sa >>> amt) : ({66'd0, a} >> amt);
      default: r = '0;
    endcase
    if (sat && op < 3) begin
      lo = sg ? -(full >>> 1) : 130'sd0;
      hi = sg ? (full >>> 1) - 1 : full - 1;
      if (r < lo) r = lo;
      if (r > hi) r = hi;
    end
    r = r & (full - 1);
    return r[63:0];
  endfunction

  function automatic logic [63:0] modelLane(int ew, logic [63:0] a, logic [63:0] b,
                                            logic [63:0] s, int fm, int op, bit sg, bit sat);
    int w = 8 << ew;
    logic [63:0] out = '0;
    logic [63:0] x, y, e;
    for (int i = 0; i < 64 / w; i++) begin
      x = (fm == 2) ? getElem(s, w, 0) : getElem(a, w, i);
      y = (fm == 2) ? getElem(a, w, i) : (fm == 1) ? getElem(s, w, 0) : getElem(b, w, i);
      e = modelElem(w, x, y, op, sg, sat);
      for (int bt = 0; bt < w; bt++) out[i*w + bt] = e[bt];
    end
    return out;
  endfunction

  function automatic logic [7:0] modelEn(int ew, int op, bit mEn, logic [7:0] m, int vl);
    logic [7:0] r = '0;
    for (int i = 0; i < 8; i++)
      r[i] = (i < (8 >> ew)) && (i < vl) && (!mEn || m[i]) && (op < 5);
    return r;
  endfunction

  // Drive at a falling edge; outputs are registered at the next rising edge
  // and sampled at the falling edge after it.
  task automatic runOp(string tag, int ew, int op, int fm, bit sg, bit sat,
                       logic [63:0] a, logic [63:0] b, logic [63:0] s,
                       bit mEn, logic [7:0] m, int vl, bit checkRes);
    ewSel = 2'(ew); opcode = 3'(op); form = 2'(fm); isSigned = sg; saturate = sat;
    vecA = a; vecB = b; scalarIn = s; maskEn = mEn; mask = m; vlen = 4'(vl);
    inValid = 1'b1;
    @(negedge clk);
    check({tag, " R9 valid"}, {63'd0, outValid}, 64'd1);
    check({tag, " wrEn"}, {56'd0, wrEn}, {56'd0, modelEn(ew, op, mEn, m, vl)});
    if (checkRes) check({tag, " result"}, result, modelLane(ew, a, b, s, fm, op, sg, sat));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFails++;
      nTests++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", nTests, nFails);
      $finish;
    end
  end

  initial begin
    logic [63:0] pa, pb, ps, res0;
    string tag;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 outValid", {63'd0, outValid}, 64'd0);
    check("R10 wrEn", {56'd0, wrEn}, 64'd0);
    check("R10 result", result, 64'd0);
    rstN = 1'b1;
    @(negedge clk);

    // R1 R2 R3 R4 R5 R6: sweep of width, op, form, sign and saturation
    for (int ew = 0; ew < 4; ew++)
      for (int op = 0; op < 5; op++)
        for (int fm = 0; fm < 3; fm++)
          for (int sg = 0; sg < 2; sg++)
            for (int sat = 0; sat < 2; sat++)
              for (int p = 0; p < 7; p++) begin
                int w = 8 << ew;
                case (p)
                  0: begin pa = {$urandom, $urandom}; pb = {$urandom, $urandom}; end
                  1: begin pa = rep(w, 64'h7fff_ffff_ffff_ffff); pb = rep(w, 64'd1); end
                  2: begin pa = rep(w, 64'h8000_0000_0000_0000 >> (64 - w)); pb = '1; end
                  3: begin pa = '1; pb = '1; end
                  4: begin pa = '0; pb = {$urandom, $urandom}; end
                  5: begin pa = {$urandom, $urandom}; pb = rep(w, 64'(w + 3)); end
                  default: begin pa = rep(w, 64'h4000_0000_0000_0001 >> (64 - w)); pb = rep(w, 64'd3); end
                endcase
                ps = (p == 1) ? 64'd1 : (p == 5) ? 64'(w + 1) : {$urandom, $urandom};
                tag = $sformatf("R1 R2 %s ew=%0d op=%0d fm=%0d sg=%0d sat=%0d p=%0d",
                                (op > 2) ? "R6 R4" : (sat ? "R5 R4" : "R3 R4"),
                                ew, op, fm, sg, sat, p);
                runOp(tag, ew, op, fm, sg[0], sat[0], pa, pb, ps, 1'b0, 8'h00, 8, 1'b1);
              end

    // R3: undefined opcodes write nothing
    for (int op = 5; op < 8; op++)
      runOp("R3 undefined opcode", 0, op, 0, 1'b0, 1'b0, 64'h1234, 64'h5678, 64'd0,
            1'b0, 8'h00, 8, 1'b0);

    // R7: mask applied when enabled, ignored when disabled
    for (int ew = 0; ew < 4; ew++)
      for (int k = 0; k < 6; k++) begin
        logic [7:0] m;
        m = (k == 0) ? 8'h00 : (k == 1) ? 8'hff : 8'($urandom);
        runOp("R7 mask on", ew, 0, 0, 1'b0, 1'b0, {$urandom, $urandom}, {$urandom, $urandom},
              64'd0, 1'b1, m, 8, 1'b1);
        runOp("R7 mask off", ew, 1, 0, 1'b1, 1'b0, {$urandom, $urandom}, {$urandom, $urandom},
              64'd0, 1'b0, m, 8, 1'b1);
      end

    // R8: vector length limits writes
    for (int ew = 0; ew < 4; ew++)
      for (int vl = 0; vl < 9; vl++)
        runOp("R8 vlen", ew, 2, 1, 1'b0, 1'b1, {$urandom, $urandom}, {$urandom, $urandom},
              {$urandom, $urandom}, 1'b1, 8'b1011_0111, vl, 1'b1);

    // R9: idle cycles hold result and clear valid and enables
    res0 = result;
    inValid = 1'b0;
    vecA = ~vecA;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R9 idle valid", {63'd0, outValid}, 64'd0);
      check("R9 idle wrEn", {56'd0, wrEn}, 64'd0);
    end
    check("R9 result held", result, res0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end
endmodule